// File: doc/BRIEF.md
# Log-Depth Binary Tree Magnitude Comparator

This block orders two unsigned operands of equal width and raises exactly one of three flags: greater, less or equal. It splits the operands into adjacent bit pairs. A row of small 2-bit compare cells turns each pair into a relation code made of two bits, "above" and "below". Identical cells then fold these codes two at a time, the more significant code on the high side, until one code remains at the root. The number of cell levels grows with the logarithm of the width rather than with the width itself.

A build-time switch selects the timing. With it off, the path from operands to flags is purely combinational and the valid flag passes straight through. With it on, the leaf row and every merge level except the root are followed by a register. A valid bit travels along with the data, so a new operand pair can enter on every cycle and its result appears log2(WIDTH)-1 cycles later.

Top module: `mag_tree_cmp`

## Requirements
- R1: `gt` is 1 exactly when `a_in` is greater than `b_in` as unsigned numbers.
- R2: `lt` is 1 exactly when `a_in` is less than `b_in` as unsigned numbers.
- R3: `eq` is 1 exactly when `a_in` and `b_in` are bit-for-bit equal.
- R4: For every operand pair, exactly one of `gt`, `lt` and `eq` is 1.
- R5: A difference in a more significant bit decides the result whatever the lower bits hold. Operands that differ only in bit WIDTH-1 are ordered by that bit. Operands that differ only in bit 0 are ordered by bit 0.
- R6: With PIPE=0, the flags follow the operands in the same cycle, and `out_valid` equals `in_valid`.
- R7: With PIPE=1, `out_valid` repeats `in_valid` delayed by log2(WIDTH)-1 clock cycles. The flags shown with it belong to the operands presented in that earlier cycle. Back-to-back inputs and gaps in `in_valid` are both carried through.
- R8: With PIPE=1, `out_valid` is 0 while `rst_n` is low (active-low, asynchronous). It stays 0 after release until a valid input has reached the output.
- R9: WIDTH must be a power of two and at least 4. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional level registers |
| rst_n | input | 1 | Asynchronous active-low reset of the level registers |
| in_valid | input | 1 | Marks the operands as a valid request |
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Marks the flags as a valid result |
| gt | output | 1 | a_in is greater than b_in |
| lt | output | 1 | a_in is less than b_in |
| eq | output | 1 | a_in equals b_in |

## Verification
In the registered build, two events land on the same clock edge. One is a fresh operand pair being captured by the leaf row. The other is an older pair's result leaving the root. The bench provokes this by streaming a new pair on every cycle, with a recurring gap in `in_valid` mixed in. At each cycle it compares the flags and `out_valid` with a history of what it fed two cycles earlier. Any mix-up between neighbouring requests, or any lost gap, shows up as a mismatch in that cycle.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  // Relation code: above = left operand larger, below = left operand smaller.
  typedef struct packed {
    logic above;
    logic below;
  } rel_t;

  // Compare two raw 2-bit slices. Both product terms of each output are
  // mutually exclusive, so XOR is used in place of OR.
  function automatic rel_t rel_leaf(input logic [1:0] a, input logic [1:0] b);
    rel_t r;
    logic hi_same;
    hi_same = ~(a[1] ^ b[1]);
    r.above = (a[1] & ~b[1]) ^ (hi_same & a[0] & ~b[0]);
    r.below = (~a[1] & b[1]) ^ (hi_same & ~a[0] & b[0]);
    return r;
  endfunction

  // Fold two relation codes; hi is the more significant one. The same cell
  // as rel_leaf with x1=hi.above, y1=hi.below, x0=lo.above, y0=lo.below.
  function automatic rel_t rel_merge(input rel_t hi, input rel_t lo);
    rel_t r;
    logic hi_same;
    hi_same = ~hi.above & ~hi.below;
    r.above = (hi.above & ~hi.below) ^ (hi_same & lo.above & ~lo.below);
    r.below = (~hi.above & hi.below) ^ (hi_same & ~lo.above & lo.below);
    return r;
  endfunction

endpackage

// File: rtl/mtc_leaf_row.sv
module mtc_leaf_row
  import mtc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         a,
  input  logic [WIDTH-1:0]         b,
  output rel_t [WIDTH/2-1:0]       pairs
);
  localparam int NP = WIDTH / 2;

  for (genvar p = 0; p < NP; p++) begin : g_cell
    // Pair p covers bits 2p+1 (high) and 2p (low).
    assign pairs[p] = rel_leaf(a[2*p+1 -: 2], b[2*p+1 -: 2]);
  end
endmodule

// File: rtl/mtc_merge_row.sv
module mtc_merge_row
  import mtc_pkg::*;
#(
  parameter int NIN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rel_t [NIN-1:0]     hi_lo,
  output rel_t [NIN/2-1:0]   merged
);
  localparam int NOUT = NIN / 2;

  for (genvar j = 0; j < NOUT; j++) begin : g_node
    // Named events for the checks below.
    rel_t node_hi, node_lo, node_out;
    logic hi_decides, kids_clean;
    assign node_hi    = hi_lo[2*j+1];
    assign node_lo    = hi_lo[2*j];
    assign node_out   = rel_merge(node_hi, node_lo);
    assign merged[j]  = node_out;
    assign hi_decides = node_hi.above ^ node_hi.below;
    assign kids_clean = ~(node_hi.above & node_hi.below) & ~(node_lo.above & node_lo.below);

    // R4: clean child codes never produce a code with both bits set.
    p_node_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      kids_clean |-> !(node_out.above && node_out.below));
    // R5: a decided high child fixes the node result.
    p_high_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kids_clean && hi_decides) |-> (node_out == node_hi));
    // R5: an undecided high child passes the low child through.
    p_low_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kids_clean && !hi_decides) |-> (node_out == node_lo));
  end
endmodule

// File: rtl/mtc_stage_reg.sv
module mtc_stage_reg #(
  parameter int W  = 2,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vi,
  input  logic [W-1:0] di,
  output logic         vo,
  output logic [W-1:0] dq
);
  if (EN) begin : g_reg
    logic         v_r;
    logic [W-1:0] d_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_r <= 1'b0;
        d_r <= '0;
      end else begin
        v_r <= vi;
        d_r <= di;
      end
    end
    assign vo = v_r;
    assign dq = d_r;

    // R7: a valid entering this stage leaves it one cycle later.
    p_valid_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vi |=> vo);
    // R7: the data carried with a valid is the data that entered.
    p_data_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vi |=> (dq == $past(di)));
  end else begin : g_wire
    assign vo = vi;
    assign dq = di;
  end
endmodule

// File: rtl/mag_tree_cmp.sv
module mag_tree_cmp
  import mtc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter bit PIPE  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             out_valid,
  output logic             gt,
  output logic             lt,
  output logic             eq
);
  localparam int NP     = WIDTH / 2;
  localparam int DEPTH  = $clog2(WIDTH);
  localparam int MERGES = DEPTH - 1;

  // R9: reject widths the tree cannot be built for.
  if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
    $error("mag_tree_cmp: WIDTH must be a power of two, at least 4");
  end

  rel_t [NP-1:0] leaf_d, leaf_q;
  logic          leaf_v;

  mtc_leaf_row #(.WIDTH(WIDTH)) u_leaf (
    .a     (a_in),
    .b     (b_in),
    .pairs (leaf_d)
  );

  mtc_stage_reg #(.W(2*NP), .EN(PIPE)) u_leaf_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .vi    (in_valid),
    .di    (leaf_d),
    .vo    (leaf_v),
    .dq    (leaf_q)
  );

  for (genvar l = 0; l < MERGES; l++) begin : g_lvl
    localparam int NIN  = NP >> l;
    localparam int NOUT = NIN / 2;
    localparam bit REG  = PIPE && (l < MERGES - 1);

    rel_t [NIN-1:0]  src;
    logic            src_v;
    rel_t [NOUT-1:0] d;
    rel_t [NOUT-1:0] q;
    logic            vq;

    if (l == 0) begin : g_first
      assign src   = leaf_q;
      assign src_v = leaf_v;
    end else begin : g_next
      assign src   = g_lvl[l-1].q;
      assign src_v = g_lvl[l-1].vq;
    end

    mtc_merge_row #(.NIN(NIN)) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .hi_lo  (src),
      .merged (d)
    );

    mtc_stage_reg #(.W(2*NOUT), .EN(REG)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .vi    (src_v),
      .di    (d),
      .vo    (vq),
      .dq    (q)
    );
  end

  rel_t root;
  assign root      = g_lvl[MERGES-1].q[0];
  assign out_valid = g_lvl[MERGES-1].vq;
  assign gt        = root.above;
  assign lt        = root.below;
  assign eq        = ~root.above & ~root.below;

  // R4: one flag only for every valid result.
  p_one_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({gt, lt, eq}) == 1));

  if (!PIPE) begin : g_comb_checks
    p_gt_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (gt == (a_in > b_in)));
    p_lt_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (lt == (a_in < b_in)));
    p_eq_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (eq == (a_in == b_in)));
    p_valid_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
  end else begin : g_pipe_checks
    // R8: first cycle after reset release carries no result.
    p_idle_after_reset_r8: assert property (@(posedge clk)
      $rose(rst_n) |-> !out_valid);
  end
endmodule

// File: tb/sim_mag_tree_cmp.sv
module sim_mag_tree_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int PLAT = 2;   // log2(8)-1 for the registered 8-bit instance

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   failures = 0;
  int   cycles = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // u0: 32-bit combinational
  logic        v0 = 1'b0, ov0, gt0, lt0, eq0;
  logic [31:0] a0 = '0, b0 = '0;
  mag_tree_cmp #(.WIDTH(32), .PIPE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v0), .a_in(a0), .b_in(b0),
    .out_valid(ov0), .gt(gt0), .lt(lt0), .eq(eq0));

  // u1: 4-bit combinational
  logic        v1 = 1'b1, ov1, gt1, lt1, eq1;
  logic [3:0]  a1 = '0, b1 = '0;
  mag_tree_cmp #(.WIDTH(4), .PIPE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .a_in(a1), .b_in(b1),
    .out_valid(ov1), .gt(gt1), .lt(lt1), .eq(eq1));

  // u2: 8-bit combinational
  logic        v2 = 1'b1, ov2, gt2, lt2, eq2;
  logic [7:0]  a2 = '0, b2 = '0;
  mag_tree_cmp #(.WIDTH(8), .PIPE(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .a_in(a2), .b_in(b2),
    .out_valid(ov2), .gt(gt2), .lt(lt2), .eq(eq2));

  // u3: 8-bit registered
  logic        v3 = 1'b0, ov3, gt3, lt3, eq3;
  logic [7:0]  a3 = '0, b3 = '0;
  mag_tree_cmp #(.WIDTH(8), .PIPE(1'b1)) u3 (
    .clk(clk), .rst_n(rst_n), .in_valid(v3), .a_in(a3), .b_in(b3),
    .out_valid(ov3), .gt(gt3), .lt(lt3), .eq(eq3));

  // Reference: native relational operators, packed as {gt, lt, eq}.
  function automatic logic [2:0] expect_flags(input logic [31:0] a, input logic [31:0] b);
    return {a > b, a < b, a == b};
  endfunction

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // R8: reset keeps the registered result invalid.
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R8 out_valid low in reset", {2'b0, ov3}, 3'b000);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R8 out_valid low after release", {2'b0, ov3}, 3'b000);
    end
  endtask

  // R1 R2 R3 R4 R6 on every 4-bit pair.
  task automatic t_all_4bit();
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 16; k++) begin
        a1 = 4'(i); b1 = 4'(k);
        #1;
        chk("R1/R2/R3 4-bit", {gt1, lt1, eq1}, expect_flags(32'(i), 32'(k)));
      end
    end
    chk("R4 4-bit one flag", {2'b0, ($countones({gt1, lt1, eq1}) == 1)}, 3'b001);
    chk("R6 4-bit valid pass", {2'b0, ov1}, 3'b001);
  endtask

  // R1 R2 R3 R4 on every 8-bit pair.
  task automatic t_all_8bit();
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 256; k++) begin
        a2 = 8'(i); b2 = 8'(k);
        #1;
        chk("R1/R2/R3/R4 8-bit", {gt2, lt2, eq2}, expect_flags(32'(i), 32'(k)));
      end
    end
  endtask

  // R5 corner cases on the 32-bit instance.
  task automatic t_corners_32();
    v0 = 1'b1;
    a0 = '0; b0 = '0; #1;
    chk("R3 all zero", {gt0, lt0, eq0}, 3'b001);
    a0 = '1; b0 = '1; #1;
    chk("R3 all one", {gt0, lt0, eq0}, 3'b001);
    a0 = 32'h8000_0000; b0 = 32'h7FFF_FFFF; #1;
    chk("R5 msb beats low ones", {gt0, lt0, eq0}, 3'b100);
    a0 = 32'h1234_5678; b0 = 32'h9234_5678; #1;
    chk("R5 differ only msb", {gt0, lt0, eq0}, 3'b010);
    a0 = 32'hA5A5_A5A5; b0 = 32'hA5A5_A5A4; #1;
    chk("R5 differ only lsb", {gt0, lt0, eq0}, 3'b100);
    a0 = 32'h0000_0000; b0 = 32'h0000_0001; #1;
    chk("R5 lsb only from zero", {gt0, lt0, eq0}, 3'b010);
    a0 = 32'hFFFF_FFFF; b0 = 32'h0; #1;
    chk("R1 max vs zero", {gt0, lt0, eq0}, 3'b100);
  endtask

  // R1 R2 R3 R6 random and near-equal vectors on 32 bits.
  task automatic t_random_32();
    for (int n = 0; n < 3000; n++) begin
      v0 = n[0];
      a0 = $urandom;
      case (n % 3)
        0: b0 = $urandom;
        1: b0 = a0 ^ (32'd1 << ($urandom % 32));
        default: b0 = a0;
      endcase
      #1;
      chk("R1/R2/R3 32-bit random", {gt0, lt0, eq0}, expect_flags(a0, b0));
      chk("R6 valid follows input", {2'b0, ov0}, {2'b0, v0});
    end
  endtask

  // R7: stream one pair per cycle with gaps through the registered build.
  task automatic t_pipe_stream();
    localparam int NV = 60;
    logic [7:0] ha [NV];
    logic [7:0] hb [NV];
    logic       hv [NV];
    for (int c = 0; c < NV + PLAT; c++) begin
      @(negedge clk);
      if (c >= PLAT) begin
        chk("R7 valid delayed", {2'b0, ov3}, {2'b0, hv[c-PLAT]});
        if (hv[c-PLAT])
          chk("R7 flags of earlier pair", {gt3, lt3, eq3},
              expect_flags(32'(ha[c-PLAT]), 32'(hb[c-PLAT])));
      end
      if (c < NV) begin
        ha[c] = 8'($urandom);
        hb[c] = (c % 4 == 0) ? ha[c] : 8'($urandom);
        hv[c] = (c % 5 != 3);
        a3 = ha[c]; b3 = hb[c]; v3 = hv[c];
      end else begin
        v3 = 1'b0;
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired got=%0d expected<=150000 cycles", cycles);
      report();
    end
  end

  initial begin
    t_reset();
    t_all_4bit();
    t_all_8bit();
    t_corners_32();
    t_random_32();
    t_pipe_stream();
    report();
  end
endmodule